// File: doc/BRIEF.md
# Secondary Clock Output Gating Controller

This block drives a bank of gated clock outputs from one reference clock. Each output can run, be parked high or be parked low. The per-output choice comes from a clock control register. Two sources write that register: a serial disable stream and a plain register write port.

The serial stream is captured on the mask input. Capture takes place while the primary reset has been released and the secondary reset is still held. Bits arrive lowest output first, one per reference clock cycle, and capture stops after one bit per output. A register write overrides the serial stream. A power-down state, combined with a strap input, forces every output low. When the strap is low, the power-down state has no effect.

In asynchronous mode the mask pin carries an alternate clock. The lower group of outputs is then derived from that clock. The upper group is parked low, and serial capture is disabled. The gating state of an output changes only on the falling edge of the reference clock, so a high phase that has already started is never cut short.

Top module: `sclk_gate_ctrl`

## Requirements
- R1: After block reset the control register reads 0 and every output toggles with the reference clock (high while it is high, low while it is low).
- R2: On each reference clock edge where the registered primary reset is released (prim_rst_n was 1 on the previous edge) and the registered secondary reset is held (sec_rst_n was 0 on the previous edge), one bit of mask_in is stored. The first stored bit goes to control bit 0, the next to bit 1, and so on. A low registered primary reset clears the register and the bit counter.
- R3: Exactly N_OUT bits are captured per window. Further mask_in bits in the same window are ignored.
- R4: A control bit of 1 parks its output at a static high level. A bit of 0 lets the output run.
- R5: A captured stream of all zeros leaves every output running. A stream of all ones parks every output high.
- R6: A write (cfg_we=1 for one cycle, while primary reset is released) loads cfg_wdata into the control register, and cfg_rdata returns it on the next cycle.
- R7: A write that arrives during a capture window takes priority and ends that window. The remaining serial bits are ignored.
- R8: With pm_strap=1 and pwr_d3hot=1, every output is held at 0, whatever the register or mode.
- R9: With pm_strap=0, pwr_d3hot has no effect on the outputs.
- R10: With async_mode=1, outputs [N_ASYNC-1:0] follow mask_in when running or sit high when their bit is 1. Outputs above them are held at 0. No serial capture takes place.
- R11: A change in gating reaches the outputs only at a falling reference edge. An output that is high when a force-low request is registered stays high until that falling edge.
- R12: Outside a capture window, mask_in has no effect on the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; source of the synchronous outputs and the block clock |
| rst_n | input | 1 | Block reset, asynchronous, active low |
| prim_rst_n | input | 1 | Primary side reset, active low |
| sec_rst_n | input | 1 | Secondary side reset, active low |
| mask_in | input | 1 | Serial disable stream; alternate clock in asynchronous mode |
| async_mode | input | 1 | 1 selects asynchronous mode |
| pm_strap | input | 1 | Enables the power-down force-low |
| pwr_d3hot | input | 1 | Device is in the power-down state |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | N_OUT | Control register write data (1 = park high) |
| cfg_rdata | output | N_OUT | Control register contents |
| clk_out | output | N_OUT | Gated clock outputs |

## Verification
The assertions check four things on every reference clock edge:
- the capture counter never passes the output count;
- a write always lands in the register;
- the register holds still outside a capture window;
- parked bits read high, forced power-down gives all zeros, and the upper group is low in asynchronous mode.

Some behaviours can only be shown by the bench's scenarios:
- the ordering of serial bits and the discarding of surplus bits;
- a write pre-empting a capture in progress;
- the ineffective power state with the strap low;
- the alternate clock reaching the lower outputs;
- the full high phase surviving a force-low request.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    typedef enum logic [1:0] {
        GATE_RUN  = 2'd0,
        GATE_HIGH = 2'd1,
        GATE_LOW  = 2'd2
    } gate_mode_e;
endpackage

// File: rtl/sclk_mask_capture.sv
module sclk_mask_capture #(
    parameter int N_OUT = 10,
    localparam int CNT_W = $clog2(N_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prim_rst_n,
    input  logic             sec_rst_n,
    input  logic             mask_in,
    input  logic             async_mode,
    input  logic             pwr_req,
    input  logic             cfg_we,
    input  logic [N_OUT-1:0] cfg_wdata,
    output logic [N_OUT-1:0] ctrl,
    output logic [CNT_W-1:0] cnt,
    output logic             win,
    output logic             prim_seen,
    output logic             pwr_force,
    output logic             async_act
);
    typedef struct packed {
        logic             prim;
        logic             sec;
        logic             pwr;
        logic             asy;
        logic [CNT_W-1:0] cnt;
        logic [N_OUT-1:0] ctrl;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    win_c;

    always_comb begin
        st_d      = st_q;
        st_d.prim = prim_rst_n;
        st_d.sec  = sec_rst_n;
        st_d.pwr  = pwr_req;
        st_d.asy  = async_mode;
        win_c     = st_q.prim && !st_q.sec && !st_q.asy
                    && (st_q.cnt < CNT_W'(N_OUT));
        if (!st_q.prim) begin
            st_d.ctrl = '0;
            st_d.cnt  = '0;
        end else if (cfg_we) begin
            st_d.ctrl = cfg_wdata;
            if (win_c) begin
                st_d.cnt = CNT_W'(N_OUT);
            end
        end else if (win_c) begin
            st_d.ctrl[st_q.cnt] = mask_in;
            st_d.cnt            = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl      = st_q.ctrl;
    assign cnt       = st_q.cnt;
    assign win       = win_c;
    assign prim_seen = st_q.prim;
    assign pwr_force = st_q.pwr;
    assign async_act = st_q.asy;
endmodule

// File: rtl/sclk_gate_policy.sv
module sclk_gate_policy
    import sclk_pkg::*;
#(
    parameter int N_OUT   = 10,
    parameter int N_ASYNC = 6
) (
    input  logic             [N_OUT-1:0] ctrl,
    input  logic                         pwr_force,
    input  logic                         async_act,
    output gate_mode_e [N_OUT-1:0]       mode
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_pol
        always_comb begin
            if (pwr_force) begin
                mode[i] = GATE_LOW;
            end else if (async_act && (i >= N_ASYNC)) begin
                mode[i] = GATE_LOW;
            end else if (ctrl[i]) begin
                mode[i] = GATE_HIGH;
            end else begin
                mode[i] = GATE_RUN;
            end
        end
    end
endmodule

// File: rtl/sclk_out_stage.sv
module sclk_out_stage
    import sclk_pkg::*;
#(
    parameter int N_OUT   = 10,
    parameter int N_ASYNC = 6
) (
    input  logic                   ref_clk,
    input  logic                   alt_clk,
    input  logic                   rst_n,
    input  logic                   async_act,
    input  gate_mode_e [N_OUT-1:0] mode_in,
    output logic       [N_OUT-1:0] clk_out
);
    gate_mode_e [N_OUT-1:0] mode_d, mode_q;

    always_comb begin
        mode_d = mode_in;
    end

    always_ff @(negedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= {N_OUT{GATE_RUN}};
        end else begin
            mode_q <= mode_d;
        end
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        logic src;
        if (i < N_ASYNC) begin : g_alt
            assign src = async_act ? alt_clk : ref_clk;
        end else begin : g_ref
            assign src = ref_clk;
        end
        assign clk_out[i] = (mode_q[i] == GATE_RUN)  ? src :
                            (mode_q[i] == GATE_HIGH) ? 1'b1 : 1'b0;
    end
endmodule

// File: rtl/sclk_gate_ctrl.sv
module sclk_gate_ctrl
    import sclk_pkg::*;
#(
    parameter int N_OUT   = 10,
    parameter int N_ASYNC = 6,
    localparam int CNT_W  = $clog2(N_OUT + 1)
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             prim_rst_n,
    input  logic             sec_rst_n,
    input  logic             mask_in,
    input  logic             async_mode,
    input  logic             pm_strap,
    input  logic             pwr_d3hot,
    input  logic             cfg_we,
    input  logic [N_OUT-1:0] cfg_wdata,
    output logic [N_OUT-1:0] cfg_rdata,
    output logic [N_OUT-1:0] clk_out
);
    logic [CNT_W-1:0]       cap_cnt;
    logic                   cap_win;
    logic                   prim_seen;
    logic                   pwr_force;
    logic                   async_act;
    logic [N_OUT-1:0]       ctrl;
    gate_mode_e [N_OUT-1:0] mode;

    sclk_mask_capture #(.N_OUT(N_OUT)) cap_i (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .prim_rst_n(prim_rst_n),
        .sec_rst_n (sec_rst_n),
        .mask_in   (mask_in),
        .async_mode(async_mode),
        .pwr_req   (pm_strap & pwr_d3hot),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl),
        .cnt       (cap_cnt),
        .win       (cap_win),
        .prim_seen (prim_seen),
        .pwr_force (pwr_force),
        .async_act (async_act)
    );

    sclk_gate_policy #(.N_OUT(N_OUT), .N_ASYNC(N_ASYNC)) pol_i (
        .ctrl     (ctrl),
        .pwr_force(pwr_force),
        .async_act(async_act),
        .mode     (mode)
    );

    sclk_out_stage #(.N_OUT(N_OUT), .N_ASYNC(N_ASYNC)) out_i (
        .ref_clk  (ref_clk),
        .alt_clk  (mask_in),
        .rst_n    (rst_n),
        .async_act(async_act),
        .mode_in  (mode),
        .clk_out  (clk_out)
    );

    assign cfg_rdata = ctrl;
endmodule

// File: rtl/sclk_gate_chk.sv
module sclk_gate_chk #(
    parameter int N_OUT   = 10,
    parameter int N_ASYNC = 6,
    localparam int CNT_W  = $clog2(N_OUT + 1)
) (
    input logic             ref_clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [N_OUT-1:0] cfg_wdata,
    input logic [N_OUT-1:0] cfg_rdata,
    input logic [N_OUT-1:0] clk_out,
    input logic [CNT_W-1:0] cap_cnt,
    input logic             cap_win,
    input logic             prim_seen,
    input logic             pwr_force,
    input logic             async_act
);
    assert_cnt_bound_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        cap_cnt <= CNT_W'(N_OUT));

    assert_write_lands_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (cfg_we && prim_seen) |=> (cfg_rdata == $past(cfg_wdata)));

    assert_reg_quiet_R12: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (prim_seen && !cap_win && !cfg_we) |=> (cfg_rdata == $past(cfg_rdata)));

    assert_parked_high_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!pwr_force && !async_act) |-> ((clk_out & cfg_rdata) == cfg_rdata));

    assert_power_low_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        pwr_force |-> (clk_out == '0));

    assert_upper_low_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (async_act && !pwr_force) |-> (clk_out[N_OUT-1:N_ASYNC] == '0));
endmodule

bind sclk_gate_ctrl sclk_gate_chk #(.N_OUT(N_OUT), .N_ASYNC(N_ASYNC)) chk_i (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .clk_out  (clk_out),
    .cap_cnt  (cap_cnt),
    .cap_win  (cap_win),
    .prim_seen(prim_seen),
    .pwr_force(pwr_force),
    .async_act(async_act)
);

// File: tb/sclk_gate_ctrl_tb.sv
module sclk_gate_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NO = 10;
    localparam int NA = 6;

    logic          ref_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prim_rst_n = 1'b0;
    logic          sec_rst_n = 1'b0;
    logic          mask_in = 1'b0;
    logic          async_mode = 1'b0;
    logic          pm_strap = 1'b0;
    logic          pwr_d3hot = 1'b0;
    logic          cfg_we = 1'b0;
    logic [NO-1:0] cfg_wdata = '0;
    logic [NO-1:0] cfg_rdata;
    logic [NO-1:0] clk_out;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        logic [NO-1:0] h;
        logic [NO-1:0] l;
        logic [NO-1:0] rd;
        string         tag;
    } sb_item_t;
    sb_item_t sbq[$];

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

    sclk_gate_ctrl #(.N_OUT(NO), .N_ASYNC(NA)) dut_i (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .prim_rst_n(prim_rst_n),
        .sec_rst_n (sec_rst_n),
        .mask_in   (mask_in),
        .async_mode(async_mode),
        .pm_strap  (pm_strap),
        .pwr_d3hot (pwr_d3hot),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .clk_out   (clk_out)
    );

    task automatic check(input string tag, input logic [NO-1:0] act, input logic [NO-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // monitor: samples one high phase and one low phase, then compares
    initial begin
        forever begin
            logic [NO-1:0] sh, sl;
            sb_item_t it;
            wait (sbq.size() > 0);
            @(posedge ref_clk); #1 sh = clk_out;
            @(negedge ref_clk); #1 sl = clk_out;
            it = sbq.pop_front();
            check({it.tag, " high phase"}, sh, it.h);
            check({it.tag, " low phase"}, sl, it.l);
            check({it.tag, " readback"}, cfg_rdata, it.rd);
        end
    end

    // driver side: computes expectation from the requirements and queues it
    task automatic expect_state(input logic [NO-1:0] rd, input logic pwr,
                                input logic asy, input logic alt, input string tag);
        sb_item_t it;
        for (int i = 0; i < NO; i++) begin
            if (pwr || (asy && i >= NA)) begin
                it.h[i] = 1'b0; it.l[i] = 1'b0;
            end else if (rd[i]) begin
                it.h[i] = 1'b1; it.l[i] = 1'b1;
            end else if (asy) begin
                it.h[i] = alt; it.l[i] = alt;
            end else begin
                it.h[i] = 1'b1; it.l[i] = 1'b0;
            end
        end
        it.rd = rd;
        it.tag = tag;
        @(posedge ref_clk); #2;
        @(posedge ref_clk); #2;
        sbq.push_back(it);
        wait (sbq.size() == 0);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge ref_clk); #2;
        end
    endtask

    task automatic reg_write(input logic [NO-1:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    // opens a capture window and streams bits, lowest output first
    task automatic shift_stream(input logic [NO+3:0] bits, input int nbits);
        prim_rst_n = 1'b0; sec_rst_n = 1'b0;
        cyc(2);
        prim_rst_n = 1'b1;
        cyc(1);
        for (int i = 0; i < nbits; i++) begin
            mask_in = bits[i];
            cyc(1);
        end
        mask_in = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        check("R1 reset readback", cfg_rdata, '0);
        expect_state('0, 0, 0, 0, "R1 reset outputs run");

        // R2 R4: ordered capture, lowest bit first
        shift_stream(14'b0000_1010011001, NO);
        expect_state(10'b1010011001, 0, 0, 0, "R2 R4 ordered capture");

        // R3: extra bits after the tenth are ignored
        shift_stream(14'b1111_0000000000, NO + 4);
        expect_state('0, 0, 0, 0, "R3 R5 surplus bits ignored, all zero runs");

        // R5: all ones parks all outputs high
        shift_stream({14{1'b1}}, NO);
        expect_state('1, 0, 0, 0, "R5 all ones parked high");

        // R2: primary reset clears the register
        prim_rst_n = 1'b0;
        cyc(2);
        check("R2 primary reset clears", cfg_rdata, '0);

        // R7: write during capture wins, remaining serial bits ignored
        prim_rst_n = 1'b1;
        cyc(1);
        mask_in = 1'b1;
        cyc(4);
        reg_write(10'h020);
        cyc(6);
        mask_in = 1'b0;
        expect_state(10'h020, 0, 0, 0, "R7 write pre-empts capture");

        // R12: outside a window mask_in is ignored
        sec_rst_n = 1'b1;
        cyc(1);
        mask_in = 1'b1;
        cyc(5);
        mask_in = 1'b0;
        expect_state(10'h020, 0, 0, 0, "R12 mask ignored outside window");

        // R6: register write and readback
        reg_write(10'h3C3);
        check("R6 readback after write", cfg_rdata, 10'h3C3);
        expect_state(10'h3C3, 0, 0, 0, "R6 written gating applied");

        // R9: strap low makes power state ineffective
        pwr_d3hot = 1'b1;
        expect_state(10'h3C3, 0, 0, 0, "R9 strap low no effect");

        // R8: strap high forces everything low
        pm_strap = 1'b1;
        expect_state(10'h3C3, 1, 0, 0, "R8 forced low");
        pm_strap = 1'b0;
        pwr_d3hot = 1'b0;
        expect_state(10'h3C3, 0, 0, 0, "R8 release restores gating");

        // R11: force-low registered at a rising edge does not cut the high phase
        reg_write('0);
        cyc(2);
        pm_strap = 1'b1; pwr_d3hot = 1'b1;
        @(posedge ref_clk); #1;
        check("R11 high phase kept after force request", clk_out, '1);
        @(negedge ref_clk); #1;
        check("R11 force applied at falling edge", clk_out, '0);
        pm_strap = 1'b0; pwr_d3hot = 1'b0;
        cyc(2);

        // R10: asynchronous mode
        reg_write(10'h003);
        async_mode = 1'b1;
        mask_in = 1'b1;
        expect_state(10'h003, 0, 1, 1, "R10 async alt clock high");
        mask_in = 1'b0;
        expect_state(10'h003, 0, 1, 0, "R10 async alt clock low");
        sec_rst_n = 1'b0;
        prim_rst_n = 1'b0;
        cyc(2);
        prim_rst_n = 1'b1;
        cyc(1);
        mask_in = 1'b1;
        cyc(NO + 2);
        mask_in = 1'b0;
        check("R10 no capture in async mode", cfg_rdata, '0);

        cyc(2);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule